// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit logical address into a physical address by looking it up in a hashed page table held in memory. It is meant to be used after a block-address lookup has already missed. The caller supplies the logical address, a flag that marks an instruction fetch, the sixteen segment register values and the table base/mask register. The caller then pulses `start`. The walker selects a segment register and checks whether that segment is a direct-store segment. It then hashes the segment's virtual segment ID with the page index and reads candidate entries through a 32-bit request/acknowledge read port.

The search covers two groups of eight 8-byte entries, the primary group first and then the secondary group. Within a group, only the first word of each entry is compared, against a packed match word. On a hit the walker reads the entry's second word and forms the physical address from it. When both groups miss, the walker reports an instruction or data storage fault, depending on the fetch flag. When the segment is a direct-store segment, it reports an error and reads no memory.

Control is a five-state machine:
- IDLE waits for `start`, and on `start` captures the inputs (transition IDLE→SEG_CHECK).
- SEG_CHECK goes to DONE for a direct-store segment and to TAG_READ otherwise.
- TAG_READ requests one entry's first word per step. A match goes to DATA_READ. The eighth primary non-match restarts TAG_READ on the secondary group. The eighth secondary non-match goes to DONE.
- DATA_READ reads the matching entry's second word, then goes to DONE.
- DONE pulses `done` for one cycle and returns to IDLE.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is chosen by logical address bits 31:28. Its low 24 bits are the virtual segment ID (VSID) used in the match word, so an entry holding another segment's VSID does not match.
- R2: The primary hash is segment register bits 18:0 XOR the page index, where the page index is logical address bits 27:12, zero-extended to 19 bits. The group address is built from the table register T and the hash H as follows: bits 31:25 are T[31:25]; bits 24:16 are T[24:16] OR (T[8:0] AND H[18:10]); bits 15:6 are H[9:0]; bits 5:0 are zero.
- R3: The secondary hash is the 19-bit complement of the primary hash. The secondary group address is built from it by the same rule as in R2.
- R4: The match word has bit 31 = 1, bits 30:7 = VSID, bit 6 = 0 for the primary group and 1 for the secondary group, and bits 5:0 = logical address bits 27:22. A stored word with bit 31 clear, or with the wrong bit 6, does not match.
- R5: The secondary group is read only when no primary entry matches. A primary hit at slot s costs exactly s+2 memory reads.
- R6: Entries are read at group address + 8*slot, with slot running from 0 upward, and the lowest matching slot wins.
- R7: On a hit, `hit`=1, `pte_word` is the word at match address + 4, `pa` = {pte_word[31:12], la[11:0]}, and `pte_loc` is the match address.
- R8: A miss in both groups costs exactly 16 reads. It sets `fault_ifetch` if `is_fetch`=1 and `fault_data` otherwise. Exactly one outcome flag is set when `done` is high.
- R9: A selected segment register with bit 31 set gives `err_direct`=1 with no memory read.
- R10: `done` is a single-cycle pulse. The outcome flags and results hold until the next `start`. After reset, `done`, all flags and `mem_req` are 0.
- R11: Once `mem_req` is raised, it and `mem_addr` stay unchanged until `mem_ack`. The read data is taken in the `mem_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken in IDLE only) |
| la | input | 32 | Logical address |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| seg_regs | input | 512 | Sixteen segment registers, register k at bits 32k+31:32k |
| tbl_reg | input | 32 | Table base (bits 31:16) and hash mask (bits 8:0) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read completion, data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| hit | output | 1 | Translation found |
| fault_ifetch | output | 1 | Miss on an instruction fetch |
| fault_data | output | 1 | Miss on a data access |
| err_direct | output | 1 | Direct-store segment selected |
| pte_word | output | 32 | Second word of the matching entry |
| pa | output | 32 | Physical address |
| pte_loc | output | 32 | Address of the matching entry |

## Verification
The sweep covers two table configurations: one with a zero hash mask, and one where mask bits fold upper hash bits into the group address. Each configuration runs under several segment/page combinations. For each combination the bench places the target entry at every slot of the primary group and then at every slot of the secondary group. This separates errors in the hash, in the group address and in the slot stride, and the exact read count shows whether the secondary group was touched too early. Decoy entries sit ahead of the target and a duplicate match sits after it. The decoys are an invalid copy, a copy with the opposite group bit and a copy with another segment's VSID. These show that every field of the match word is compared and that the lowest slot wins. Double misses with both fetch flag values, and a direct-store segment, cover the non-hit outcomes.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG_CHECK,
        ST_TAG_READ,
        ST_DATA_READ,
        ST_DONE
    } walk_state_t;

    localparam int WORD_W      = 32;
    localparam int HASH_W      = 19;
    localparam int ENTRY_BYTES = 8;
endpackage

// File: rtl/hpt_grp_addr.sv
module hpt_grp_addr
    import hpt_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [WORD_W-1:0] seg_val,
    input  logic [WORD_W-1:0] la,
    input  logic [WORD_W-1:0] tbl_val,
    input  logic              pass_sec,
    input  logic [IDX_W-1:0]  slot,
    output logic [WORD_W-1:0] tag_addr,
    output logic [WORD_W-1:0] match_word
);
    localparam int PAD_W = WORD_W - IDX_W - 3;

    logic [HASH_W-1:0] hash_p;
    logic [HASH_W-1:0] hash_sel;
    logic [WORD_W-1:0] grp_base;
    logic              unused_bits;

    always_comb begin
        hash_p   = seg_val[HASH_W-1:0] ^ {3'b000, la[27:12]};
        hash_sel = pass_sec ? ~hash_p : hash_p;
        grp_base = {tbl_val[31:25],
                    tbl_val[24:16] | (tbl_val[8:0] & hash_sel[18:10]),
                    hash_sel[9:0],
                    6'b000000};
        tag_addr   = grp_base | {{PAD_W{1'b0}}, slot, 3'b000};
        match_word = {1'b1, seg_val[23:0], pass_sec, la[27:22]};
    end

    assign unused_bits = ^{seg_val[31:24], la[31:28], la[11:0], tbl_val[15:9]};
endmodule

// File: rtl/hpt_walk_fsm.sv
module hpt_walk_fsm
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    parameter int IDX_W         = $clog2(GROUP_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             seg_direct,
    input  logic             mem_ack,
    input  logic             tag_eq,
    output walk_state_t      state,
    output logic             pass_sec,
    output logic [IDX_W-1:0] slot,
    output logic             mem_req,
    output logic             sel_data,
    output logic             done,
    output logic             load,
    output logic             ev_hit,
    output logic             ev_miss,
    output logic             ev_err,
    output logic             ev_match
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_t state_nx;
    logic        last_slot;

    assign last_slot = (slot == LAST_SLOT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_SEG_CHECK;
            ST_SEG_CHECK: state_nx = seg_direct ? ST_DONE : ST_TAG_READ;
            ST_TAG_READ: begin
                if (mem_ack) begin
                    if (tag_eq)                     state_nx = ST_DATA_READ;
                    else if (last_slot && pass_sec) state_nx = ST_DONE;
                end
            end
            ST_DATA_READ: if (mem_ack) state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pass_sec <= 1'b0;
            slot     <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SEG_CHECK) begin
                pass_sec <= 1'b0;
                slot     <= '0;
            end else if (state == ST_TAG_READ && mem_ack && !tag_eq) begin
                if (last_slot) begin
                    pass_sec <= 1'b1;
                    slot     <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    always_comb begin
        mem_req  = (state == ST_TAG_READ) || (state == ST_DATA_READ);
        sel_data = (state == ST_DATA_READ);
        done     = (state == ST_DONE);
        load     = (state == ST_IDLE) && start;
        ev_err   = (state == ST_SEG_CHECK) && seg_direct;
        ev_match = (state == ST_TAG_READ) && mem_ack && tag_eq;
        ev_miss  = (state == ST_TAG_READ) && mem_ack && !tag_eq && last_slot && pass_sec;
        ev_hit   = (state == ST_DATA_READ) && mem_ack;
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEG_CHECK && seg_direct) |=> !mem_req);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int N_SEG         = 16,
    parameter int GROUP_ENTRIES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [WORD_W-1:0]         la,
    input  logic                      is_fetch,
    input  logic [N_SEG*WORD_W-1:0]   seg_regs,
    input  logic [WORD_W-1:0]         tbl_reg,
    output logic                      mem_req,
    output logic [WORD_W-1:0]         mem_addr,
    input  logic                      mem_ack,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic                      done,
    output logic                      hit,
    output logic                      fault_ifetch,
    output logic                      fault_data,
    output logic                      err_direct,
    output logic [WORD_W-1:0]         pte_word,
    output logic [WORD_W-1:0]         pa,
    output logic [WORD_W-1:0]         pte_loc
);
    localparam int IDX_W = $clog2(GROUP_ENTRIES);
    localparam int SEL_W = $clog2(N_SEG);

    logic [WORD_W-1:0] la_q, seg_q, tbl_q;
    logic              fetch_q;
    logic [WORD_W-1:0] tag_addr, match_word;
    logic              pass_sec, sel_data, load;
    logic              ev_hit, ev_miss, ev_err, ev_match;
    logic [IDX_W-1:0]  slot;
    walk_state_t       state;
    logic [WORD_W-1:0] seg_pick;

    assign seg_pick = seg_regs[int'(la[WORD_W-1 -: SEL_W]) * WORD_W +: WORD_W];

    hpt_grp_addr #(.IDX_W(IDX_W)) u_addr (
        .seg_val    (seg_q),
        .la         (la_q),
        .tbl_val    (tbl_q),
        .pass_sec   (pass_sec),
        .slot       (slot),
        .tag_addr   (tag_addr),
        .match_word (match_word)
    );

    hpt_walk_fsm #(.GROUP_ENTRIES(GROUP_ENTRIES), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .seg_direct (seg_q[31]),
        .mem_ack    (mem_ack),
        .tag_eq     (mem_rdata == match_word),
        .state      (state),
        .pass_sec   (pass_sec),
        .slot       (slot),
        .mem_req    (mem_req),
        .sel_data   (sel_data),
        .done       (done),
        .load       (load),
        .ev_hit     (ev_hit),
        .ev_miss    (ev_miss),
        .ev_err     (ev_err),
        .ev_match   (ev_match)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q         <= '0;
            seg_q        <= '0;
            tbl_q        <= '0;
            fetch_q      <= 1'b0;
            hit          <= 1'b0;
            fault_ifetch <= 1'b0;
            fault_data   <= 1'b0;
            err_direct   <= 1'b0;
            pte_word     <= '0;
            pte_loc      <= '0;
        end else if (load) begin
            la_q         <= la;
            seg_q        <= seg_pick;
            tbl_q        <= tbl_reg;
            fetch_q      <= is_fetch;
            hit          <= 1'b0;
            fault_ifetch <= 1'b0;
            fault_data   <= 1'b0;
            err_direct   <= 1'b0;
        end else begin
            if (ev_match) pte_loc <= tag_addr;
            if (ev_hit) begin
                hit      <= 1'b1;
                pte_word <= mem_rdata;
            end
            if (ev_miss) begin
                fault_ifetch <= fetch_q;
                fault_data   <= !fetch_q;
            end
            if (ev_err) err_direct <= 1'b1;
        end
    end

    assign mem_addr = sel_data ? (pte_loc | 32'd4) : tag_addr;
    assign pa       = {pte_word[31:12], la_q[11:0]};

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({hit, fault_ifetch, fault_data, err_direct}) == 1));

    p_word_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !sel_data) |-> (mem_addr[2:0] == 3'd0));

    p_data_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && sel_data) |-> (mem_addr == (pte_loc | 32'd4)));

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable({hit, fault_ifetch, fault_data, err_direct}));
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   la = '0;
    logic          is_fetch = 1'b0;
    logic [511:0]  seg_regs = '0;
    logic [31:0]   tbl_reg = '0;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          done, hit, fault_ifetch, fault_data, err_direct;
    logic [31:0]   pte_word, pa, pte_loc;

    logic [31:0]   mem [logic [31:0]];
    int            reads = 0;
    int            n_tests = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .la(la), .is_fetch(is_fetch),
        .seg_regs(seg_regs), .tbl_reg(tbl_reg), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .hit(hit), .fault_ifetch(fault_ifetch),
        .fault_data(fault_data), .err_direct(err_direct),
        .pte_word(pte_word), .pa(pa), .pte_loc(pte_loc)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            reads     <= reads + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] grp_of(input logic [31:0] t, input logic [18:0] h);
        logic [31:0] mid;
        mid = ((t >> 16) & 32'h1FF) | ((t & 32'h1FF) & ((32'(h) >> 10) & 32'h1FF));
        return (t & 32'hFE00_0000) | (mid << 16) | ((32'(h) & 32'h3FF) << 6);
    endfunction

    function automatic logic [31:0] tag_of(input logic [31:0] sv, input bit sec,
                                           input logic [15:0] pg);
        return {1'b1, sv[23:0], sec, pg[15:10]};
    endfunction

    task automatic walk(output bit timed_out, output int nreads);
        int r0;
        r0 = reads;
        timed_out = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin timed_out = 1'b0; break; end
            @(negedge clk);
        end
        nreads = reads - r0;
        if (timed_out) chk(1'b0, "R10", "watchdog: done never rose", 32'd0, 32'd1);
    endtask

    initial begin
        logic [31:0] cfgs [2];
        cfgs[0] = 32'h0010_0000;
        cfgs[1] = 32'h0200_0003;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0, "R10", "reset done/req", {30'd0, done, mem_req}, 32'd0);
        chk({hit, fault_ifetch, fault_data, err_direct} == 4'd0, "R10", "reset flags",
            {28'd0, hit, fault_ifetch, fault_data, err_direct}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int c = 0; c < 2; c++) begin
            for (int li = 0; li < 4; li++) begin
                for (int sc = 0; sc < 18; sc++) begin
                    logic [3:0]  sidx;
                    logic [15:0] pg;
                    logic [11:0] off;
                    logic [31:0] sv, ga_p, ga_s, ga, tw, ew, loc;
                    logic [18:0] h1;
                    int          s, exp_reads, nr;
                    bit          sec, to;
                    sidx = 4'((li * 5 + 3) % 16);
                    pg   = 16'h1234 + 16'(li) * 16'h2F1B + 16'(c) * 16'h0777;
                    off  = 12'h0A0 + 12'(li * 13 + sc);
                    for (int k = 0; k < 16; k++)
                        seg_regs[k*32 +: 32] = (32'h0003_1000 + 32'(k) * 32'h0001_2345 + 32'(c) * 32'h11) & 32'h00FF_FFFF;
                    tbl_reg  = cfgs[c];
                    la       = {sidx, pg, off};
                    is_fetch = (sc == 16);
                    sv   = seg_regs[int'(sidx)*32 +: 32];
                    h1   = sv[18:0] ^ {3'b000, pg};
                    ga_p = grp_of(tbl_reg, h1);
                    ga_s = grp_of(tbl_reg, ~h1);
                    mem.delete();
                    sec = (sc >= 8 && sc < 16);
                    s   = sc % 8;
                    ga  = sec ? ga_s : ga_p;
                    tw  = tag_of(sv, sec, pg);
                    ew  = {20'hA0000 + 20'(c * 64 + li * 18 + sc), 12'h5C3};
                    // decoys in primary group
                    mem[ga_p + 0]  = tag_of(sv, 1'b0, pg) & 32'h7FFF_FFFF;
                    mem[ga_p + 8]  = tag_of(sv, 1'b1, pg);
                    mem[ga_p + 16] = tag_of(seg_regs[int'(sidx ^ 4'h1)*32 +: 32], 1'b0, pg);
                    mem[ga_s + 0]  = tag_of(sv, 1'b0, pg);
                    if (sc < 16) begin
                        if (s + 1 < 8) begin
                            mem[ga + 32'(s + 1) * 8]     = tw;
                            mem[ga + 32'(s + 1) * 8 + 4] = 32'hDEAD_0FFF;
                        end
                        mem[ga + 32'(s) * 8]     = tw;
                        mem[ga + 32'(s) * 8 + 4] = ew;
                    end
                    loc = ga + 32'(s) * 8;
                    walk(to, nr);
                    if (!to) begin
                        if (sc < 16) begin
                            exp_reads = (sec ? 8 : 0) + s + 2;
                            chk(hit == 1'b1, sec ? "R3" : "R2", "hit flag", {31'd0, hit}, 32'd1);
                            chk(pte_loc == loc, sec ? "R3" : "R6", "entry location", pte_loc, loc);
                            chk(pte_word == ew, "R7", "entry second word", pte_word, ew);
                            chk(pa == {ew[31:12], off}, "R7", "physical address", pa, {ew[31:12], off});
                            chk(nr == exp_reads, sec ? "R4" : "R5", "read count", 32'(nr), 32'(exp_reads));
                            chk(!fault_ifetch && !fault_data && !err_direct, "R1", "no other flag",
                                {29'd0, fault_ifetch, fault_data, err_direct}, 32'd0);
                        end else begin
                            chk(nr == 16, "R8", "miss read count", 32'(nr), 32'd16);
                            chk(hit == 1'b0, "R8", "miss hit flag", {31'd0, hit}, 32'd0);
                            chk(fault_ifetch == is_fetch && fault_data == !is_fetch, "R8", "fault kind",
                                {30'd0, fault_ifetch, fault_data}, {30'd0, is_fetch, !is_fetch});
                        end
                        @(negedge clk);
                        chk(done == 1'b0, "R10", "done single pulse", {31'd0, done}, 32'd0);
                        if (sc == 3) begin
                            repeat (3) @(negedge clk);
                            chk(hit == 1'b1 && pa == {ew[31:12], off}, "R10", "result held", pa, {ew[31:12], off});
                        end
                    end
                end
            end
        end

        // direct-store segment
        for (int f = 0; f < 2; f++) begin
            int  nr;
            bit  to;
            mem.delete();
            la = 32'h7123_4567;
            is_fetch = f[0];
            seg_regs[7*32 +: 32] = 32'h8000_0042;
            walk(to, nr);
            if (!to) begin
                chk(err_direct == 1'b1, "R9", "direct-store error", {31'd0, err_direct}, 32'd1);
                chk(nr == 0, "R9", "no memory read", 32'(nr), 32'd0);
                chk(!hit && !fault_ifetch && !fault_data, "R9", "other flags clear",
                    {29'd0, hit, fault_ifetch, fault_data}, 32'd0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL R10 global watchdog expired: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule